// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block recovers asynchronous serial frames from a single input line. It samples the line 16 times per bit period, using an enable pulse supplied from outside. It confirms each start bit at the middle of the bit, then samples every following bit at its centre. The received character goes into a one-entry holding register. Framing, overrun and parity faults are reported on three sticky flags.

The frame can carry 7 or 8 data bits, with an optional parity bit that is checked against an odd or even sense. An address-marking mode is also provided. In that mode the frame always has 8 data bits and no parity bit, and the bit that follows the data is captured as an address/data marker. The receiver checks a single stop bit in every mode.

Dropping the enable while a frame is arriving does not cut that frame short: it is completed and stored, and no new start bit is accepted afterwards. Software-side logic reads the holding register by pulsing a read strobe, and clears the fault flags with a clear strobe.

The controller has six states:
- S_IDLE waits for a falling edge while enabled.
- S_START checks the start bit at mid-bit. A high sample leads back to S_IDLE (glitch). A low sample leads to S_DATA.
- S_DATA shifts in the data bits, least significant first. After the last bit it moves to S_ADR in address-marking mode, otherwise to S_PAR when parity is on, otherwise to S_STOP.
- S_PAR samples the parity bit and moves to S_STOP.
- S_ADR samples the marker bit and moves to S_STOP.
- S_STOP samples the stop bit, hands the frame to the holding register and returns to S_IDLE.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, rx_full, err_frame, err_over, err_parity and rx_addr are 0 and rx_data is 0.
- R2: A frame is a low start bit followed by data bits, least significant bit first, and a high stop bit. With len8=1 all 8 data bits appear on rx_data, and rx_full becomes 1 once the frame is complete.
- R3: With len8=0 and mp_mode=0, 7 data bits are received, and rx_data[7] reads 0.
- R4: With par_en=1 and mp_mode=0, the bit after the data is a parity bit. Even sense (par_odd=0) expects an even total number of ones across the data and parity bits; odd sense (par_odd=1) expects an odd total. A mismatch sets err_parity.
- R5: Only one stop bit is checked. A low stop sample sets err_frame. A start bit that begins directly after a single high stop bit is accepted.
- R6: If a frame completes while rx_full is 1 and no read is made in that cycle, err_over is set and rx_data and rx_addr keep the earlier frame.
- R7: A one-cycle pulse on rd_strobe clears rx_full.
- R8: A pulse on err_clr clears err_frame, err_over and err_parity together. While err_clr is 0 and no frame completes, the three flags hold their values. If a flag is set in the same cycle as a clear, the set wins.
- R9: A low pulse on rx_in that has ended before the mid-bit check of the start bit produces no frame.
- R10: With mp_mode=1, the frame has 8 data bits and no parity bit, whatever the values of len8 and par_en. The bit after the data is presented on rx_addr (1 = address, 0 = data).
- R11: When rx_en falls in the middle of a frame, that frame is still completed and stored. While rx_en is 0 and the receiver is idle, no frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| mp_mode | input | 1 | Address-marking mode |
| err_clr | input | 1 | Clear strobe for the three fault flags |
| rd_strobe | input | 1 | Holding-register read pulse |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Holding register contains unread data |
| err_frame | output | 1 | Stop bit sampled low |
| err_over | output | 1 | Frame lost because the holding register was full |
| err_parity | output | 1 | Parity mismatch |
| rx_addr | output | 1 | Address/data marker of the stored frame |

## Verification
The assertions assume the following about the inputs:
- par_en, par_odd, len8 and mp_mode stay constant for the whole of a frame.
- os_tick pulses at a steady rate.
- rd_strobe and err_clr are single-cycle pulses.

The bench meets these assumptions in the following ways:
- It changes configuration only while the line is idle.
- It ties the oversampling enable high, so one bit period is 16 clocks.
- It issues strobes only between frames, so no strobe coincides with frame completion.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_ADR,
        S_STOP
    } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx_s,
    input  logic          rx_en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          len8,
    input  logic          mp_mode,
    output logic          done,
    output logic [DW-1:0] f_data,
    output logic          f_fe,
    output logic          f_pe,
    output logic          f_adr
);
    localparam int CW   = $clog2(OS);
    localparam int IW   = $clog2(DW);
    localparam int HALF = OS / 2;

    rx_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [DW-1:0] shreg;
    logic          rx_prev;

    wire           full_len  = mp_mode || len8;
    wire [IW-1:0]  last_idx  = full_len ? IW'(DW-1) : IW'(DW-2);
    wire           fall      = tick && rx_prev && !rx_s;
    wire           at_mid    = tick && (cnt == CW'(HALF-1));
    wire           at_bit    = tick && (cnt == CW'(OS-1));

    assign f_data = full_len ? shreg : {1'b0, shreg[DW-1:1]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (rx_en && fall) nxt = S_START;
            S_START: if (at_mid) nxt = rx_s ? S_IDLE : S_DATA;
            S_DATA:  if (at_bit && idx == last_idx)
                         nxt = mp_mode ? S_ADR : (par_en ? S_PAR : S_STOP);
            S_PAR:   if (at_bit) nxt = S_STOP;
            S_ADR:   if (at_bit) nxt = S_STOP;
            S_STOP:  if (at_bit) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            rx_prev <= 1'b1;
            done    <= 1'b0;
            f_fe    <= 1'b0;
            f_pe    <= 1'b0;
            f_adr   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) rx_prev <= rx_s;
            unique case (state)
                S_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                end
                S_START: if (tick) begin
                    cnt <= at_mid ? '0 : cnt + 1'b1;
                    if (at_mid) begin
                        f_pe  <= 1'b0;
                        f_adr <= 1'b0;
                    end
                end
                default: if (tick) begin
                    cnt <= at_bit ? '0 : cnt + 1'b1;
                    if (at_bit) begin
                        unique case (state)
                            S_DATA: begin
                                shreg <= {rx_s, shreg[DW-1:1]};
                                idx   <= idx + 1'b1;
                            end
                            S_PAR:  f_pe  <= (^f_data) ^ rx_s ^ par_odd;
                            S_ADR:  f_adr <= rx_s;
                            S_STOP: begin
                                f_fe <= !rx_s;
                                done <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !rx_en) |=> state == S_IDLE);
    assert_glitch_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && at_mid && rx_s) |=> (state == S_IDLE && !done));
    assert_mp_no_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAR) |-> !mp_mode);
    assert_single_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/srx_buffer.sv
module srx_buffer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] f_data,
    input  logic          f_fe,
    input  logic          f_pe,
    input  logic          f_adr,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          fe,
    output logic          ov,
    output logic          pe,
    output logic          adr
);
    wire lost = done && full && !rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            fe   <= 1'b0;
            ov   <= 1'b0;
            pe   <= 1'b0;
            adr  <= 1'b0;
        end else begin
            fe <= (fe && !clr) || (done && f_fe);
            pe <= (pe && !clr) || (done && f_pe);
            ov <= (ov && !clr) || lost;
            if (done && !lost) begin
                data <= f_data;
                adr  <= f_adr;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
        end
    end

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd) |=> ov);
    assert_overrun_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && full && !rd) |=> ($stable(data) && $stable(adr)));
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !full);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> (!fe && !ov && !pe));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !done) |=> ($stable(fe) && $stable(ov) && $stable(pe)));
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
    parameter int OS_RATE     = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              len8,
    input  logic              mp_mode,
    input  logic              err_clr,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_frame,
    output logic              err_over,
    output logic              err_parity,
    output logic              rx_addr
);
    logic              rx_s;
    logic              done;
    logic [DATA_W-1:0] f_data;
    logic              f_fe, f_pe, f_adr;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    srx_fsm #(.OS(OS_RATE), .DW(DATA_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .rx_s   (rx_s),
        .rx_en  (rx_en),
        .par_en (par_en),
        .par_odd(par_odd),
        .len8   (len8),
        .mp_mode(mp_mode),
        .done   (done),
        .f_data (f_data),
        .f_fe   (f_fe),
        .f_pe   (f_pe),
        .f_adr  (f_adr)
    );

    srx_buffer #(.DW(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .f_data(f_data),
        .f_fe  (f_fe),
        .f_pe  (f_pe),
        .f_adr (f_adr),
        .rd    (rd_strobe),
        .clr   (err_clr),
        .data  (rx_data),
        .full  (rx_full),
        .fe    (err_frame),
        .ov    (err_over),
        .pe    (err_parity),
        .adr   (rx_addr)
    );
endmodule

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       rx_en = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       len8 = 1'b1;
    logic       mp_mode = 1'b0;
    logic       err_clr = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_frame, err_over, err_parity, rx_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    serial_frame_rx u_serial_frame_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .len8(len8),
        .mp_mode(mp_mode), .err_clr(err_clr), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .err_frame(err_frame),
        .err_over(err_over), .err_parity(err_parity), .rx_addr(rx_addr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input bit v);
        rx_in = v;
        repeat (16) @(negedge clk);
    endtask

    // drop < 0: rx_en unchanged; otherwise rx_en falls before data bit 'drop'
    task automatic send_frame(input logic [7:0] d, input int nb, input bit has_par,
                              input bit pb, input bit has_adr, input bit av,
                              input bit stopv, input int drop, input int gap);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            if (i == drop) rx_en = 1'b0;
            drive_bit(d[i]);
        end
        if (has_par) drive_bit(pb);
        if (has_adr) drive_bit(av);
        drive_bit(stopv);
        rx_in = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic strobes();
        err_clr = 1'b1;
        rd_strobe = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 full", rx_full, 0);
        check("R1 data", rx_data, 0);
        check("R1 flags", {err_frame, err_over, err_parity, rx_addr}, 0);
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 8, 0, 0, 0, 0, 1, -1, 24);
        check("R2 data A5", rx_data, 8'hA5);
        check("R2 full", rx_full, 1);
        check("R2 no errors", {err_frame, err_over, err_parity}, 0);
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
        check("R7 read clears full", rx_full, 0);
        send_frame(8'h3C, 8, 0, 0, 0, 0, 1, -1, 24);
        check("R2 data 3C", rx_data, 8'h3C);
        strobes();
    endtask

    task automatic t_seven();
        len8 = 1'b0;
        send_frame(8'hD5, 7, 0, 0, 0, 0, 1, -1, 24);
        check("R3 seven bit data", rx_data, 8'h55);
        check("R3 full", rx_full, 1);
        strobes();
        len8 = 1'b1;
    endtask

    task automatic t_parity();
        logic [7:0] d;
        bit p;
        bit odd;
        par_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            odd = k[1];
            p   = k[0];
            d   = odd ? 8'h07 : 8'h03;
            par_odd = odd;
            send_frame(d, 8, 1, p, 0, 0, 1, -1, 24);
            check("R4 parity data", rx_data, d);
            check("R4 parity flag", err_parity, int'(((^d) ^ p) != odd));
            strobes();
        end
        par_en = 1'b0;
        par_odd = 1'b0;
    endtask

    task automatic t_framing();
        send_frame(8'h5A, 8, 0, 0, 0, 0, 0, -1, 24);
        check("R5 framing error", err_frame, 1);
        repeat (5) @(negedge clk);
        check("R8 flag holds", err_frame, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
        check("R8 clear", {err_frame, err_over, err_parity}, 0);
        strobes();
    endtask

    task automatic t_back_to_back();
        send_frame(8'h11, 8, 0, 0, 0, 0, 1, -1, 0);
        send_frame(8'h22, 8, 0, 0, 0, 0, 1, -1, 24);
        check("R5 R6 second frame caused overrun", err_over, 1);
        check("R6 data kept", rx_data, 8'h11);
        check("R5 no framing error", err_frame, 0);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
        check("R8 overrun cleared", err_over, 0);
        strobes();
    endtask

    task automatic t_glitch();
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
        check("R9 glitch no frame", rx_full, 0);
        send_frame(8'h81, 8, 0, 0, 0, 0, 1, -1, 24);
        check("R9 next frame ok", rx_data, 8'h81);
        strobes();
    endtask

    task automatic t_mp();
        mp_mode = 1'b1;
        par_en = 1'b1;
        len8 = 1'b0;
        send_frame(8'hC3, 8, 0, 0, 1, 1, 1, -1, 24);
        check("R10 mp data", rx_data, 8'hC3);
        check("R10 address marker", rx_addr, 1);
        check("R10 no parity or framing", {err_parity, err_frame}, 0);
        strobes();
        send_frame(8'h3E, 8, 0, 0, 1, 0, 1, -1, 24);
        check("R10 data marker", rx_addr, 0);
        check("R10 mp data 2", rx_data, 8'h3E);
        strobes();
        mp_mode = 1'b0;
        par_en = 1'b0;
        len8 = 1'b1;
    endtask

    task automatic t_disable();
        send_frame(8'h96, 8, 0, 0, 0, 0, 1, 2, 24);
        check("R11 frame completed after disable", rx_full, 1);
        check("R11 data", rx_data, 8'h96);
        strobes();
        send_frame(8'h44, 8, 0, 0, 0, 0, 1, -1, 24);
        check("R11 disabled ignores frame", rx_full, 0);
        check("R11 data unchanged", rx_data, 8'h96);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        t_reset();
        t_basic();
        t_seven();
        t_parity();
        t_framing();
        t_back_to_back();
        t_glitch();
        t_mp();
        t_disable();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule